// File: doc/BRIEF.md
# Packet Buffer Allocation Unit

This block tracks the ownership of a pool of fixed-size packet buffers (sixteen by default, each 2 KiB) for a small Ethernet controller. It keeps two ownership bitmaps, one for buffers held by the receive path and one for buffers held by transmit. Each bitmap has one bit per buffer. A host command can allocate a buffer for transmit. The receive path can request a buffer for itself in any cycle. Either requester gets the lowest-numbered buffer that neither bitmap currently holds. Release commands free a buffer, and an MMU reset command frees every buffer at once.

A successful transmit allocation does three things: it writes the granted number into an allocation result field, it sets a sticky allocation-done flag, and it pulses a grant output. A receive grant pulses its own grant output and presents the number on a separate output. A request that finds no free buffer gets a one-cycle fail pulse and leaves all state unchanged. The completion queues of the controller live outside this block. On an MMU reset the block pulses a flush output so that those queues empty in step with the bitmaps.

No data streams through the block. Every pin is a plain control or status signal, so there is no valid/ready back-pressure. A command is taken in every cycle where `cmd_valid` is high, and a receive request in every cycle where `rx_req` is high. Every result is registered.

Top module: `pba_alloc_unit`

## Requirements
- R1: While `rst` is high at a clock edge, both bitmaps, `alloc_result`, `rx_pnum`, `alloc_done` and all pulse outputs become zero.
- R2: A command with `cmd_op`=1 (transmit allocate) grants the lowest index whose bit is clear in the OR of both bitmaps. One edge later, `tx_grant` pulses for one cycle, the bit is set in `tx_mask` and `alloc_result` holds the index.
- R3: A cycle with `rx_req` high grants the lowest free index. One edge later, `rx_grant` pulses, the bit is set in `rx_mask` and `rx_pnum` holds the index.
- R4: `alloc_done` goes high with every transmit grant. It stays high until a command with `cmd_op`=4 (acknowledge), an MMU reset or `rst`.
- R5: When no buffer is free, the request gives a one-cycle `tx_fail` or `rx_fail` pulse. Neither bitmap changes, and `alloc_result` and `alloc_done` keep their values.
- R6: When a transmit allocate and `rx_req` arrive in the same cycle, transmit takes the lowest free index and receive takes the next one. If only one buffer is free, transmit gets it and `rx_fail` pulses.
- R7: A command with `cmd_op`=3 (release) clears bit `rel_pnum` in both bitmaps. A `rel_pnum` of `NUM_BUFS` or above changes nothing.
- R8: A command with `cmd_op`=2 (MMU reset) clears both bitmaps and `alloc_done`, and pulses `queue_flush` for one cycle. An `rx_req` in that same cycle is not granted and gets `rx_fail`.
- R9: An `rx_req` in the same cycle as a release is served from the bitmaps as they stood before that release.
- R10: With `cmd_valid` high, `cmd_op` values 0, 5, 6 and 7 change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_op | input | 3 | Command opcode (1 allocate, 2 MMU reset, 3 release, 4 acknowledge) |
| rel_pnum | input | 8 | Packet number freed by a release command |
| rx_req | input | 1 | Receive path asks for a buffer |
| tx_grant | output | 1 | One-cycle pulse: transmit allocation granted |
| tx_fail | output | 1 | One-cycle pulse: transmit allocation refused |
| rx_grant | output | 1 | One-cycle pulse: receive allocation granted |
| rx_fail | output | 1 | One-cycle pulse: receive allocation refused |
| alloc_result | output | 8 | Last number granted to transmit |
| rx_pnum | output | 8 | Last number granted to receive |
| alloc_done | output | 1 | Sticky allocation-done status flag |
| queue_flush | output | 1 | One-cycle pulse telling the completion queues to empty |
| rx_mask | output | 16 | Receive ownership bitmap |
| tx_mask | output | 16 | Transmit ownership bitmap |

## Verification
Every result of this block is due exactly one clock edge after the cycle that carries its stimulus. This covers grants, fails, the bitmaps, the result fields, the flag and the flush pulse. The driver applies each stimulus at a falling edge and pushes the expected state for the following rising edge into a queue. The monitor pops that entry at the next falling edge, so each comparison lines up with one stimulus cycle and samples a value that has settled. Cases that must leave state alone (a refused request, an out-of-range release, an unused opcode) are judged by the bitmaps and result fields seen in that same cycle.

// File: rtl/pba_pkg.sv
package pba_pkg;

  typedef enum logic [2:0] {
    OP_NOP       = 3'd0,
    OP_ALLOC_TX  = 3'd1,
    OP_MMU_RESET = 3'd2,
    OP_RELEASE   = 3'd3,
    OP_ACK_ALLOC = 3'd4
  } pba_op_e;

endpackage

// File: rtl/pba_first_free.sv
module pba_first_free #(
  parameter int NUM_BUFS = 16,
  localparam int IDX_W = $clog2(NUM_BUFS)
) (
  input  logic [NUM_BUFS-1:0] busy_i,
  output logic                found_o,
  output logic [IDX_W-1:0]    idx_o
);

  // Walk from the top so the last hit kept is the lowest clear index.
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = NUM_BUFS - 1; i >= 0; i--) begin
      if (!busy_i[i]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/pba_owner_maps.sv
module pba_owner_maps #(
  parameter int NUM_BUFS = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clr_all_i,
  input  logic [NUM_BUFS-1:0] set_tx_i,
  input  logic [NUM_BUFS-1:0] set_rx_i,
  input  logic [NUM_BUFS-1:0] free_i,
  output logic [NUM_BUFS-1:0] rx_mask_o,
  output logic [NUM_BUFS-1:0] tx_mask_o
);

  for (genvar b = 0; b < NUM_BUFS; b++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst || clr_all_i) begin
        tx_mask_o[b] <= 1'b0;
        rx_mask_o[b] <= 1'b0;
      end else begin
        if (set_tx_i[b])    tx_mask_o[b] <= 1'b1;
        else if (free_i[b]) tx_mask_o[b] <= 1'b0;
        if (set_rx_i[b])    rx_mask_o[b] <= 1'b1;
        else if (free_i[b]) rx_mask_o[b] <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/pba_alloc_unit.sv
module pba_alloc_unit
  import pba_pkg::*;
#(
  parameter int NUM_BUFS = 16,
  parameter int PNUM_W   = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cmd_valid,
  input  logic [2:0]          cmd_op,
  input  logic [PNUM_W-1:0]   rel_pnum,
  input  logic                rx_req,
  output logic                tx_grant,
  output logic                tx_fail,
  output logic                rx_grant,
  output logic                rx_fail,
  output logic [PNUM_W-1:0]   alloc_result,
  output logic [PNUM_W-1:0]   rx_pnum,
  output logic                alloc_done,
  output logic                queue_flush,
  output logic [NUM_BUFS-1:0] rx_mask,
  output logic [NUM_BUFS-1:0] tx_mask
);

  localparam int IDX_W = $clog2(NUM_BUFS);

  logic                do_tx, do_flush, do_rel, do_ack;
  logic [NUM_BUFS-1:0] busy, tx_pick, rx_pick, rel_vec;
  logic                tx_found, rx_found, tx_take, rx_take;
  logic [IDX_W-1:0]    tx_idx, rx_idx;

  // Command decode
  always_comb begin
    do_tx = 1'b0; do_flush = 1'b0; do_rel = 1'b0; do_ack = 1'b0;
    if (cmd_valid) begin
      case (pba_op_e'(cmd_op))
        OP_ALLOC_TX:  do_tx    = 1'b1;
        OP_MMU_RESET: do_flush = 1'b1;
        OP_RELEASE:   do_rel   = 1'b1;
        OP_ACK_ALLOC: do_ack   = 1'b1;
        default: ;
      endcase
    end
  end

  assign busy = rx_mask | tx_mask;

  // Transmit picks first; receive searches what transmit left over.
  pba_first_free #(.NUM_BUFS(NUM_BUFS)) u_tx_scan (
    .busy_i(busy), .found_o(tx_found), .idx_o(tx_idx)
  );

  assign tx_take = do_tx && tx_found;
  assign tx_pick = tx_take ? (NUM_BUFS'(1) << tx_idx) : '0;

  pba_first_free #(.NUM_BUFS(NUM_BUFS)) u_rx_scan (
    .busy_i(busy | tx_pick), .found_o(rx_found), .idx_o(rx_idx)
  );

  assign rx_take = rx_req && !do_flush && rx_found;
  assign rx_pick = rx_take ? (NUM_BUFS'(1) << rx_idx) : '0;

  assign rel_vec = (do_rel && (rel_pnum < PNUM_W'(NUM_BUFS)))
                   ? (NUM_BUFS'(1) << rel_pnum[IDX_W-1:0]) : '0;

  pba_owner_maps #(.NUM_BUFS(NUM_BUFS)) u_maps (
    .clk(clk), .rst(rst), .clr_all_i(do_flush),
    .set_tx_i(tx_pick), .set_rx_i(rx_pick), .free_i(rel_vec),
    .rx_mask_o(rx_mask), .tx_mask_o(tx_mask)
  );

  // Result fields, flag and pulses
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_grant     <= 1'b0;
      tx_fail      <= 1'b0;
      rx_grant     <= 1'b0;
      rx_fail      <= 1'b0;
      alloc_result <= '0;
      rx_pnum      <= '0;
      alloc_done   <= 1'b0;
      queue_flush  <= 1'b0;
    end else begin
      tx_grant    <= tx_take;
      tx_fail     <= do_tx && !tx_found;
      rx_grant    <= rx_take;
      rx_fail     <= rx_req && !rx_take;
      queue_flush <= do_flush;
      if (tx_take) alloc_result <= PNUM_W'(tx_idx);
      if (rx_take) rx_pnum      <= PNUM_W'(rx_idx);
      if (do_flush || do_ack) alloc_done <= 1'b0;
      else if (tx_take)       alloc_done <= 1'b1;
    end
  end

  // R2: a transmit grant marks a bit that was clear before
  a_r2_grant_new_bit: assert property (@(posedge clk) disable iff (rst)
    tx_grant |-> (((tx_mask >> alloc_result) & NUM_BUFS'(1)) != '0) &&
                 ((($past(tx_mask | rx_mask)) >> alloc_result) & NUM_BUFS'(1)) == '0);

  // R3: receive grant and fail never together
  a_r3_rx_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(rx_grant && rx_fail));

  // R4: the flag is up whenever a transmit grant is reported
  a_r4_done_on_grant: assert property (@(posedge clk) disable iff (rst)
    tx_grant |-> alloc_done);

  // R5: a refused transmit request leaves the transmit map and result alone
  a_r5_fail_keeps_state: assert property (@(posedge clk) disable iff (rst)
    tx_fail |-> $stable(tx_mask) && $stable(alloc_result));

  // R6: one buffer never belongs to both paths
  a_r6_maps_disjoint: assert property (@(posedge clk) disable iff (rst)
    (rx_mask & tx_mask) == '0);

  // R8: after a flush both maps are empty and the flag is down
  a_r8_flush_clears: assert property (@(posedge clk) disable iff (rst)
    queue_flush |-> (rx_mask == '0) && (tx_mask == '0) && !alloc_done);

endmodule

// File: tb/pba_alloc_unit_tb_top.sv
`timescale 1ns/1ps
module pba_alloc_unit_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_valid = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic [7:0] rel_pnum = 8'd0;
  logic       rx_req = 1'b0;
  logic       tx_grant, tx_fail, rx_grant, rx_fail, alloc_done, queue_flush;
  logic [7:0] alloc_result, rx_pnum;
  logic [15:0] rx_mask, tx_mask;

  always #2.5 clk = ~clk;

  pba_alloc_unit dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .rel_pnum(rel_pnum), .rx_req(rx_req),
    .tx_grant(tx_grant), .tx_fail(tx_fail), .rx_grant(rx_grant), .rx_fail(rx_fail),
    .alloc_result(alloc_result), .rx_pnum(rx_pnum), .alloc_done(alloc_done),
    .queue_flush(queue_flush), .rx_mask(rx_mask), .tx_mask(tx_mask)
  );

  typedef struct {
    bit txg, txf, rxg, rxf, done, flush;
    bit [7:0] res, rxn;
    bit [15:0] rxm, txm;
    string tag;
  } exp_t;

  exp_t sb[$];
  int compared = 0, mismatched = 0;
  bit finished = 1'b0;

  // reference state
  bit [15:0] mrx = '0, mtx = '0;
  bit [7:0]  mres = '0, mrxn = '0;
  bit        mdone = 1'b0;

  function automatic int lowest_free(input bit [15:0] b);
    for (int i = 0; i < 16; i++) if (!b[i]) return i;
    return -1;
  endfunction

  task automatic step(input bit v, input bit [2:0] op, input bit [7:0] num,
                      input bit rx, input string tag);
    exp_t e;
    bit [15:0] busy;
    int t, r;
    e = '{default: 0, tag: tag};
    busy = mrx | mtx;
    t = -1;
    if (v && op == 3'd2) begin
      mrx = '0; mtx = '0; mdone = 1'b0; e.flush = 1'b1;
      if (rx) e.rxf = 1'b1;
    end else begin
      if (v && op == 3'd1) begin
        t = lowest_free(busy);
        if (t >= 0) begin
          mtx[t] = 1'b1; mres = 8'(t); mdone = 1'b1; e.txg = 1'b1;
          busy[t] = 1'b1;
        end else e.txf = 1'b1;
      end
      if (rx) begin
        r = lowest_free(busy);
        if (r >= 0) begin mrx[r] = 1'b1; mrxn = 8'(r); e.rxg = 1'b1; end
        else e.rxf = 1'b1;
      end
      if (v && op == 3'd3 && num < 16) begin mrx[num[3:0]] = 1'b0; mtx[num[3:0]] = 1'b0; end
      if (v && op == 3'd4) mdone = 1'b0;
    end
    e.res = mres; e.rxn = mrxn; e.done = mdone; e.rxm = mrx; e.txm = mtx;
    cmd_valid = v; cmd_op = op; rel_pnum = num; rx_req = rx;
    @(posedge clk);
    sb.push_back(e);
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 3'd0; rel_pnum = 8'd0; rx_req = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    mrx = '0; mtx = '0; mres = '0; mrxn = '0; mdone = 1'b0;
  endtask

  // Monitor: compare one expected entry per falling edge
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      compared++;
      if (tx_grant !== e.txg || tx_fail !== e.txf || rx_grant !== e.rxg ||
          rx_fail !== e.rxf || alloc_done !== e.done || queue_flush !== e.flush ||
          alloc_result !== e.res || rx_pnum !== e.rxn || rx_mask !== e.rxm ||
          tx_mask !== e.txm) begin
        mismatched++;
        $display("FAIL %s: got txg=%0b txf=%0b rxg=%0b rxf=%0b done=%0b fl=%0b res=%0d rxn=%0d rxm=%h txm=%h / exp txg=%0b txf=%0b rxg=%0b rxf=%0b done=%0b fl=%0b res=%0d rxn=%0d rxm=%h txm=%h",
                 e.tag, tx_grant, tx_fail, rx_grant, rx_fail, alloc_done, queue_flush,
                 alloc_result, rx_pnum, rx_mask, tx_mask,
                 e.txg, e.txf, e.rxg, e.rxf, e.done, e.flush, e.res, e.rxn, e.rxm, e.txm);
      end
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    step(0, 3'd0, 8'd0, 0, "R1 reset state");
    step(1, 3'd1, 8'd0, 0, "R2 tx alloc 0");
    step(1, 3'd1, 8'd0, 0, "R2 tx alloc 1");
    step(1, 3'd1, 8'd0, 0, "R4 tx alloc 2 flag");
    step(1, 3'd4, 8'd0, 0, "R4 ack clears flag");
    step(0, 3'd0, 8'd0, 1, "R3 rx alloc 3");
    step(1, 3'd3, 8'd1, 0, "R7 release 1");
    step(1, 3'd1, 8'd0, 0, "R2 tx fills hole 1");
    step(1, 3'd3, 8'd20, 0, "R7 out-of-range release");
    step(1, 3'd0, 8'd2, 0, "R10 op0");
    step(1, 3'd5, 8'd2, 0, "R10 op5");
    step(1, 3'd6, 8'd2, 0, "R10 op6");
    step(1, 3'd7, 8'd2, 0, "R10 op7");
    step(1, 3'd1, 8'd0, 1, "R6 tx 4 rx 5");
    for (int k = 0; k < 10; k++) step(1, 3'd1, 8'd0, 0, "R2 fill pool");
    step(1, 3'd1, 8'd0, 0, "R5 tx full fail");
    step(0, 3'd0, 8'd0, 1, "R5 rx full fail");
    step(1, 3'd3, 8'd7, 1, "R9 release with rx");
    step(0, 3'd0, 8'd0, 1, "R9 rx gets 7");
    step(1, 3'd3, 8'd3, 0, "R7 release rx-owned 3");
    step(1, 3'd1, 8'd0, 1, "R6 one free tx wins");
    step(1, 3'd2, 8'd0, 1, "R8 mmu reset with rx");
    step(1, 3'd1, 8'd0, 1, "R8 alloc after flush");
    do_reset();
    step(0, 3'd0, 8'd0, 0, "R1 reset mid-run");
    @(negedge clk);
    @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    #500000;
    if (!finished) begin
      finished = 1'b1;
      mismatched++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule